// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block sequences one page-program operation of an embedded flash array. Software drives it through a three-bit command register that holds a program-enable bit, a high-voltage-enable bit and a suspend bit. Software also drives a data write port. The first data write that the block accepts after a program starts is the interlock write. It fixes the target page and, unless an erase is suspended, selects the shadow or normal address space. After that write, each data write lands in one of four 32-bit slots of a 128-bit page buffer.

Setting high-voltage enable starts a modelled program pulse of a fixed number of cycles. When the pulse completes, the block writes the buffered page into the array and raises done with a pass flag. If software clears high-voltage enable mid-pulse, the program is aborted. The page then receives a known garbage pattern, which stands in for indeterminate cells, and the pass flag stays low. The pulse can be suspended and resumed. An abort is refused while the pulse is suspended.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, st_pgm, st_ehv, st_psus, st_pass, st_space and arr_we are 0, and st_done is 1.
- R2: A program starts when a command write raises the program bit (bit 0) while it and high voltage are low. A program also starts when high-voltage enable (bit 1) is cleared while high voltage is on and the program bit stays set. A start re-arms the interlock, so a new interlock write is needed, and fills all four buffer words with all-ones.
- R3: The first data write accepted after a start latches dat_addr[ADDR_W-1:4] as the page. Address bits above bit 3 of later writes are ignored.
- R4: When ers_susp is low during the interlock write, st_space takes the value of dat_shadow.
- R5: When ers_susp is high during the interlock write, st_space keeps its previous value.
- R6: dat_addr[3:2] selects buffer word k, which is placed at page bits [32k+31:32k]. The last write to a word wins, and words that were never written stay all-ones.
- R7: A command write that sets high-voltage enable is ignored unless the program bit is set, an interlock write has occurred, and the write keeps bit 0 set.
- R8: A command write that clears the program bit while high voltage is off ends the sequence. It makes no array write and discards the interlock.
- R9: Accepting high voltage drives st_done and st_pass low. After PULSE_LEN unsuspended cycles, st_done and st_pass go high and one arr_we cycle carries the buffered page, the page address and the space.
- R10: Clearing high-voltage enable while done is low and suspend is low aborts the program: st_ehv goes 0, st_done goes 1 and st_pass goes 0. One arr_we cycle then carries page data whose word k equals 32'h5A5A0000 XOR page XOR k.
- R11: The suspend bit (bit 2) is writable only while the pulse runs. While suspended, the pulse count is frozen, and clearing high-voltage enable is ignored.
- R12: Data writes are ignored while the program bit is clear or high voltage is on.
- R13: Command writes do not change the program bit while high voltage is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Command register write strobe |
| ctl_wdata | input | 3 | Command value: bit2 suspend, bit1 high voltage, bit0 program |
| ers_susp | input | 1 | An erase is currently suspended |
| dat_we | input | 1 | Data write strobe |
| dat_addr | input | ADDR_W | Data write byte address |
| dat_shadow | input | 1 | Data write targets the shadow space |
| dat_wdata | input | 32 | Data write word |
| st_pgm | output | 1 | Program bit |
| st_ehv | output | 1 | High-voltage-enable bit |
| st_psus | output | 1 | Suspend bit |
| st_done | output | 1 | Operation done |
| st_pass | output | 1 | Last program passed |
| st_space | output | 1 | Space-select status (1 = shadow) |
| arr_we | output | 1 | Array page write strobe |
| arr_space | output | 1 | Space of the array write |
| arr_page | output | ADDR_W-4 | Page of the array write |
| arr_data | output | 128 | Page data of the array write |

## Verification
The bench targets these faults:
- Ignoring the interlock rule. A design that accepts high voltage without an interlock would raise st_ehv.
- Decoding the upper address bits of later writes. This would redirect or lose words.
- Updating the space bit during an erase-suspended program. This would flip st_space.
- Honouring an abort during suspend. This would write garbage instead of resuming.
- Counting during suspend. This would shorten the pulse.

A cycle model of every requirement tracks the status bits and each array write under seeded random command and data traffic. The directed cases cover:
- last-write-wins
- words left unwritten
- termination before high voltage
- writes ignored while idle or under high voltage

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  localparam int WORD_W = 32;
  localparam int N_WORDS = 4;
  localparam int PAGE_DATA_W = WORD_W * N_WORDS;
  localparam logic [31:0] GARBAGE_SEED = 32'h5A5A_0000;

  typedef struct packed {
    logic psus;
    logic ehv;
    logic pgm;
  } ctl_t;

  function automatic logic [1:0] word_sel(input logic [3:0] low_addr);
    return low_addr[3:2];
  endfunction

  function automatic logic [PAGE_DATA_W-1:0] garbage_page(input logic [31:0] page);
    logic [PAGE_DATA_W-1:0] r;
    for (int k = 0; k < N_WORDS; k++) begin
      r[k*WORD_W +: WORD_W] = GARBAGE_SEED ^ page ^ 32'(k);
    end
    return r;
  endfunction

endpackage

// File: rtl/fpc_seq_ctrl.sv
module fpc_seq_ctrl
  import flash_prog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  ctl_t ctl_wd,
  input  logic ilk,
  input  logic fin,
  output logic pgm_q,
  output logic ehv_q,
  output logic psus_q,
  output logic done_q,
  output logic pass_q,
  output logic hv_on,
  output logic abort,
  output logic term,
  output logic seq_clr
);

  logic hv_end;
  logic start;

  always_comb begin
    hv_on  = ctl_we & ctl_wd.ehv & ctl_wd.pgm & ~ehv_q & pgm_q & ilk;
    abort  = ctl_we & ~ctl_wd.ehv & ehv_q & ~done_q & ~psus_q & ~fin;
    hv_end = ctl_we & ~ctl_wd.ehv & ehv_q & (done_q | fin);
    start  = (ctl_we & ~ehv_q & ~pgm_q & ctl_wd.pgm) | abort | hv_end;
    term   = ctl_we & ~ehv_q & pgm_q & ~ctl_wd.pgm;
    seq_clr = start | term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_q  <= 1'b0;
      ehv_q  <= 1'b0;
      psus_q <= 1'b0;
      done_q <= 1'b1;
      pass_q <= 1'b0;
    end else begin
      if (ctl_we && !ehv_q) pgm_q <= ctl_wd.pgm;

      if (hv_on) ehv_q <= 1'b1;
      else if (abort || hv_end) ehv_q <= 1'b0;

      if (abort || hv_end) psus_q <= 1'b0;
      else if (ctl_we && ehv_q && !done_q && !fin) psus_q <= ctl_wd.psus;

      if (hv_on) done_q <= 1'b0;
      else if (fin || abort) done_q <= 1'b1;

      if (hv_on || abort) pass_q <= 1'b0;
      else if (fin) pass_q <= 1'b1;
    end
  end

endmodule

// File: rtl/fpc_pulse_timer.sv
module fpc_pulse_timer #(
  parameter int PULSE_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hv_on,
  input  logic run,
  output logic fin
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign fin = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (hv_on || fin) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/fpc_page_buf.sv
module fpc_page_buf
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int PAGE_W = ADDR_W - 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   acc,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   shadow,
  input  logic                   ers_susp,
  input  logic [WORD_W-1:0]      wdata,
  output logic                   ilk_q,
  output logic [PAGE_W-1:0]      page_q,
  output logic                   space_q,
  output logic [PAGE_DATA_W-1:0] page_data
);

  logic [WORD_W-1:0] word_q [N_WORDS];
  logic              first_wr;

  assign first_wr = acc && !ilk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilk_q   <= 1'b0;
      page_q  <= '0;
      space_q <= 1'b0;
    end else begin
      if (clr) ilk_q <= 1'b0;
      else if (acc) ilk_q <= 1'b1;
      if (first_wr) page_q <= addr[ADDR_W-1:4];
      if (first_wr && !ers_susp) space_q <= shadow;
    end
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[k] <= '1;
      else if (clr) word_q[k] <= '1;
      else if (acc && word_sel(addr[3:0]) == 2'(k)) word_q[k] <= wdata;
    end
    assign page_data[k*WORD_W +: WORD_W] = word_q[k];
  end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PULSE_LEN = 64,
  localparam int PAGE_W = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic              ers_susp,
  input  logic              dat_we,
  input  logic [ADDR_W-1:0] dat_addr,
  input  logic              dat_shadow,
  input  logic [31:0]       dat_wdata,
  output logic              st_pgm,
  output logic              st_ehv,
  output logic              st_psus,
  output logic              st_done,
  output logic              st_pass,
  output logic              st_space,
  output logic              arr_we,
  output logic              arr_space,
  output logic [PAGE_W-1:0] arr_page,
  output logic [127:0]      arr_data
);

  ctl_t                   cw;
  logic                   ilk_w, fin_w, hv_on_w, abort_w, term_w, clr_w;
  logic                   acc_w, run_w;
  logic [PAGE_W-1:0]      page_w;
  logic [PAGE_DATA_W-1:0] buf_w;

  assign cw    = ctl_t'(ctl_wdata);
  assign run_w = st_ehv & ~st_done & ~st_psus;
  assign acc_w = dat_we & st_pgm & ~st_ehv & ~clr_w;

  fpc_seq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(cw),
    .ilk(ilk_w), .fin(fin_w),
    .pgm_q(st_pgm), .ehv_q(st_ehv), .psus_q(st_psus),
    .done_q(st_done), .pass_q(st_pass),
    .hv_on(hv_on_w), .abort(abort_w), .term(term_w), .seq_clr(clr_w)
  );

  fpc_pulse_timer #(.PULSE_LEN(PULSE_LEN)) i_timer (
    .clk(clk), .rst_n(rst_n), .hv_on(hv_on_w), .run(run_w), .fin(fin_w)
  );

  fpc_page_buf #(.ADDR_W(ADDR_W)) i_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .acc(acc_w),
    .addr(dat_addr), .shadow(dat_shadow), .ers_susp(ers_susp),
    .wdata(dat_wdata), .ilk_q(ilk_w), .page_q(page_w),
    .space_q(st_space), .page_data(buf_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_we    <= 1'b0;
      arr_space <= 1'b0;
      arr_page  <= '0;
      arr_data  <= '0;
    end else begin
      arr_we <= fin_w | abort_w;
      if (fin_w || abort_w) begin
        arr_space <= st_space;
        arr_page  <= page_w;
        arr_data  <= fin_w ? buf_w : garbage_page(32'(page_w));
      end
    end
  end

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
  input logic clk,
  input logic rst_n,
  input logic st_pgm,
  input logic st_ehv,
  input logic st_psus,
  input logic st_done,
  input logic st_pass,
  input logic arr_we,
  input logic hv_on,
  input logic abort,
  input logic term,
  input logic ilk
);

  AST_HV_NEEDS_ILK: assert property (@(posedge clk) disable iff (!rst_n)
    hv_on |-> (ilk && st_pgm)); // R7
  AST_HV_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    hv_on |=> (st_ehv && !st_done && !st_pass)); // R9
  AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    st_pass |-> st_done); // R9
  AST_ARR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> st_done); // R9
  AST_ABORT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st_done && !st_pass && !st_ehv && arr_we)); // R10
  AST_SUSP_HOLDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
    (st_psus && !st_done) |=> st_ehv); // R11
  AST_PGM_HELD_HV: assert property (@(posedge clk) disable iff (!rst_n)
    st_ehv |=> $stable(st_pgm)); // R13
  AST_TERM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (!st_pgm && !arr_we)); // R8

endmodule

bind flash_prog_ctrl fpc_checker i_chk (
  .clk(clk), .rst_n(rst_n), .st_pgm(st_pgm), .st_ehv(st_ehv),
  .st_psus(st_psus), .st_done(st_done), .st_pass(st_pass),
  .arr_we(arr_we), .hv_on(hv_on_w), .abort(abort_w),
  .term(term_w), .ilk(ilk_w)
);

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;

  localparam int AW = 20;
  localparam int PL = 8;
  localparam int PW = AW - 4;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic ers_susp = 1'b0;
  logic dat_we = 1'b0;
  logic [AW-1:0] dat_addr = '0;
  logic dat_shadow = 1'b0;
  logic [31:0] dat_wdata = '0;
  logic st_pgm, st_ehv, st_psus, st_done, st_pass, st_space;
  logic arr_we, arr_space;
  logic [PW-1:0] arr_page;
  logic [127:0] arr_data;

  flash_prog_ctrl #(.ADDR_W(AW), .PULSE_LEN(PL)) i_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ers_susp(ers_susp), .dat_we(dat_we), .dat_addr(dat_addr),
    .dat_shadow(dat_shadow), .dat_wdata(dat_wdata),
    .st_pgm(st_pgm), .st_ehv(st_ehv), .st_psus(st_psus),
    .st_done(st_done), .st_pass(st_pass), .st_space(st_space),
    .arr_we(arr_we), .arr_space(arr_space), .arr_page(arr_page),
    .arr_data(arr_data)
  );

  always #10ns clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  // reference model state
  logic m_pgm = 0, m_ehv = 0, m_psus = 0, m_done = 1, m_pass = 0;
  logic m_space = 0, m_ilk = 0, m_awe = 0, m_aspace = 0;
  logic [PW-1:0] m_page = '0, m_apage = '0;
  logic [31:0] m_buf [4] = '{ONES, ONES, ONES, ONES};
  logic [127:0] m_adata = '0;
  int m_cnt = 0;

  // last observed array write
  logic [PW-1:0] cap_page = '0;
  logic [127:0] cap_data = '0;
  logic cap_space = 1'b0;
  int cap_n = 0;

  function automatic logic [127:0] exp_garbage(input logic [PW-1:0] pg);
    logic [127:0] v = '0;
    for (int k = 3; k >= 0; k--) v = {v[95:0], (32'h5A5A_0000 ^ {16'h0, pg}) ^ k[31:0]};
    return v;
  endfunction

  function automatic logic [127:0] pack4(input logic [31:0] w3, w2, w1, w0);
    return {w3, w2, w1, w0};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic fin, hv_on, abort, hv_end, start, term, clr, acc;
    fin    = m_ehv & ~m_done & ~m_psus & (m_cnt == PL - 1);
    hv_on  = ctl_we & ctl_wdata[1] & ctl_wdata[0] & ~m_ehv & m_pgm & m_ilk;
    abort  = ctl_we & ~ctl_wdata[1] & m_ehv & ~m_done & ~m_psus & ~fin;
    hv_end = ctl_we & ~ctl_wdata[1] & m_ehv & (m_done | fin);
    start  = (ctl_we & ~m_ehv & ~m_pgm & ctl_wdata[0]) | abort | hv_end;
    term   = ctl_we & ~m_ehv & m_pgm & ~ctl_wdata[0];
    clr    = start | term;
    acc    = dat_we & m_pgm & ~m_ehv & ~clr;
    m_awe = fin | abort;
    if (fin | abort) begin
      m_aspace = m_space;
      m_apage  = m_page;
      m_adata  = fin ? pack4(m_buf[3], m_buf[2], m_buf[1], m_buf[0]) : exp_garbage(m_page);
    end
    if (hv_on || fin) m_cnt = 0;
    else if (m_ehv & ~m_done & ~m_psus) m_cnt++;
    if (abort | hv_end) m_psus = 0;
    else if (ctl_we & m_ehv & ~m_done & ~fin) m_psus = ctl_wdata[2];
    if (ctl_we & ~m_ehv) m_pgm = ctl_wdata[0];
    if (hv_on) begin m_ehv = 1; m_done = 0; m_pass = 0; end
    else if (abort) begin m_ehv = 0; m_done = 1; m_pass = 0; end
    else begin
      if (hv_end) m_ehv = 0;
      if (fin) begin m_done = 1; m_pass = 1; end
    end
    if (acc && !m_ilk) begin
      m_page = dat_addr[AW-1:4];
      if (!ers_susp) m_space = dat_shadow;
    end
    if (clr) begin
      m_ilk = 0;
      for (int k = 0; k < 4; k++) m_buf[k] = ONES;
    end else if (acc) begin
      m_ilk = 1;
      m_buf[dat_addr[3:2]] = dat_wdata;
    end
  endtask

  task automatic compare();
    chk("R13", "st_pgm", st_pgm, m_pgm);
    chk("R7", "st_ehv", st_ehv, m_ehv);
    chk("R11", "st_psus", st_psus, m_psus);
    chk("R9", "st_done", st_done, m_done);
    chk("R9", "st_pass", st_pass, m_pass);
    chk("R4", "st_space", st_space, m_space);
    chk("R9", "arr_we", arr_we, m_awe);
    if (arr_we) begin
      chk("R6", "arr_data", arr_data, m_adata);
      chk("R3", "arr_page", arr_page, m_apage);
      chk("R4", "arr_space", arr_space, m_aspace);
      cap_page = arr_page; cap_data = arr_data; cap_space = arr_space; cap_n++;
    end
  endtask

  task automatic step(input logic cwe, input logic [2:0] cwd, input logic dwe,
                      input logic [AW-1:0] a, input logic sh, input logic [31:0] d);
    ctl_we = cwe; ctl_wdata = cwd; dat_we = dwe;
    dat_addr = a; dat_shadow = sh; dat_wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic ctl(input logic [2:0] v);
    step(1'b1, v, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic dwr(input logic [AW-1:0] a, input logic sh, input logic [31:0] d);
    step(1'b0, 3'b000, 1'b1, a, sh, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'b000, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ncap;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pgm", st_pgm, 0);  chk("R1", "ehv", st_ehv, 0);
    chk("R1", "psus", st_psus, 0); chk("R1", "done", st_done, 1);
    chk("R1", "pass", st_pass, 0); chk("R1", "space", st_space, 0);
    chk("R1", "arr_we", arr_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: high voltage before interlock is ignored
    ctl(3'b001);
    ctl(3'b011);
    chk("R7", "ehv w/o interlock", st_ehv, 0);
    chk("R7", "done w/o interlock", st_done, 1);
    // R3 R4 R6: interlock plus later writes with stray upper bits
    dwr({16'h0123, 4'h0}, 1'b1, 32'h1111_0000);
    dwr({16'h0777, 4'h8}, 1'b0, 32'h2222_2222);
    dwr({16'h0ABC, 4'h8}, 1'b0, 32'h3333_3333);
    chk("R4", "space after interlock", st_space, 1);
    ctl(3'b011);
    chk("R9", "done low under hv", st_done, 0);
    idle(PL - 1);
    chk("R9", "done before pulse end", st_done, 0);
    idle(1);
    chk("R9", "done at pulse end", st_done, 1);
    chk("R9", "pass at pulse end", st_pass, 1);
    chk("R3", "page", cap_page, 16'h0123);
    chk("R6", "page data", cap_data, pack4(ONES, 32'h3333_3333, ONES, 32'h1111_0000));
    chk("R4", "array space", cap_space, 1);

    // R2: clearing hv with program held restarts and re-arms interlock
    ctl(3'b001);
    chk("R2", "pgm held", st_pgm, 1);
    ctl(3'b011);
    chk("R2", "hv needs new interlock", st_ehv, 0);

    // R5 R11 R10: erase-suspended program, suspend, abort
    ers_susp = 1'b1;
    dwr({16'h0456, 4'h4}, 1'b0, 32'h4444_4444);
    chk("R5", "space kept", st_space, 1);
    ctl(3'b011);
    idle(2);
    ctl(3'b111);
    idle(3 * PL);
    chk("R11", "frozen while suspended", st_done, 0);
    chk("R11", "psus set", st_psus, 1);
    ctl(3'b101);
    chk("R11", "abort refused in suspend", st_ehv, 1);
    ctl(3'b011);
    idle(1);
    ncap = cap_n;
    ctl(3'b001);
    chk("R10", "abort ehv", st_ehv, 0);
    chk("R10", "abort done", st_done, 1);
    chk("R10", "abort pass", st_pass, 0);
    chk("R10", "abort wrote", cap_n, ncap + 1);
    chk("R10", "garbage", cap_data, exp_garbage(16'h0456));
    chk("R10", "garbage page", cap_page, 16'h0456);
    ers_susp = 1'b0;

    // R8: termination before high voltage
    dwr({16'h0999, 4'h0}, 1'b0, 32'h5555_5555);
    ncap = cap_n;
    ctl(3'b000);
    chk("R8", "pgm cleared", st_pgm, 0);
    chk("R8", "no array write", arr_we, 0);
    ctl(3'b001);
    ctl(3'b011);
    chk("R8", "interlock discarded", st_ehv, 0);
    chk("R8", "still no array write", cap_n, ncap);

    // R12 R13: ignored data writes and program bit under high voltage
    ctl(3'b000);
    dwr({16'h0055, 4'h4}, 1'b0, 32'h6666_6666);
    ctl(3'b001);
    dwr({16'h00AA, 4'h0}, 1'b0, 32'h7777_7777);
    ctl(3'b011);
    dwr({16'h00AA, 4'hC}, 1'b0, 32'h8888_8888);
    ctl(3'b010);
    chk("R13", "pgm held under hv", st_pgm, 1);
    idle(PL - 2);
    chk("R12", "done", st_done, 1);
    chk("R12", "ignored writes", cap_data, pack4(ONES, ONES, ONES, 32'h7777_7777));
    chk("R12", "page", cap_page, 16'h00AA);
    chk("R4", "space normal", cap_space, 0);
    ctl(3'b000);
    ctl(3'b000);

    // constrained random traffic checked against the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] cv;
      logic cwe, dwe;
      if (i % 64 == 0) ers_susp = ($urandom % 4) == 0;
      cwe = ($urandom % 6) == 0;
      case ($urandom % 8)
        0, 5: cv = 3'b001;
        1, 3: cv = 3'b011;
        2:    cv = 3'b111;
        4:    cv = 3'b000;
        6:    cv = 3'b101;
        default: cv = 3'($urandom);
      endcase
      dwe = ($urandom % 3) == 0;
      step(cwe, cv, dwe, AW'($urandom), 1'($urandom), $urandom);
    end
    finish_run();
  end

endmodule